// File: doc/BRIEF.md
# Program Counter with Read Offset

This block keeps the address of the instruction currently being executed by a core that supports two instruction-set modes. The word mode uses only 32-bit instructions. The compact mode mixes 16-bit and 32-bit instructions. On each enabled step the block moves the address forward by the size of the instruction. A write to the program counter sends execution to a new target instead.

The block also drives a second output for instructions that read the program counter as an operand. This value is a fixed offset from the current instruction's address, and the offset depends only on the mode. It is formed from the registered instruction address, not from any fetch counter. Software therefore sees the same value however deep the surrounding pipeline is. In compact mode the offset is the same for 16-bit and 32-bit instructions.

Top module: `pc_ofs_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the instruction address equals the reset vector parameter (default 0x0000_0040), until the first write or advance.
- R2: In word mode (mode_i = 0), an advance with no write raises the address by 4, and the size flag has no effect.
- R3: In compact mode (mode_i = 1), an advance with no write raises the address by 2 when size_wide_i = 0 and by 4 when size_wide_i = 1.
- R4: In word mode the read value equals the current instruction address plus 8.
- R5: In compact mode the read value equals the current instruction address plus 4, whatever the value of size_wide_i.
- R6: A write loads the written data into the address on the next clock edge. In word mode bits 1:0 are forced to zero, and in compact mode bit 0 is forced to zero.
- R7: When a write and an advance are requested in the same cycle, the write wins and no step is added.
- R8: With neither advance nor write requested, the address keeps its value.
- R9: Advance and read-value arithmetic both wrap modulo 2^32.
- R10: The read value is combinational from the registered address and mode_i, so it is valid in the same cycle as the address it belongs to.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Instruction-set mode: 0 = word, 1 = compact |
| size_wide_i | input | 1 | Size of the current instruction in compact mode: 1 = 32-bit, 0 = 16-bit |
| adv_i | input | 1 | Move on to the next sequential instruction |
| wr_en_i | input | 1 | Write the program counter (branch) |
| wr_data_i | input | 32 | Branch target |
| cur_addr_o | output | 32 | Address of the current instruction |
| pc_rd_o | output | 32 | Program counter value seen by an operand read |

## Verification
The embedded assertions check on every cycle that:
- the step size matches the mode and size flag;
- an idle cycle leaves the address unchanged;
- a write lands aligned and takes priority over an advance;
- the read value keeps its fixed mode-dependent distance from the address.

Only the bench's scenarios can show the absolute values. These include the reset vector, the exact target produced from each unaligned write pattern, and the correct results when arithmetic crosses the top of the address space. They also show that reset in the middle of a run returns the address to the vector.

// File: rtl/pc_ofs_pkg.sv
package pc_ofs_pkg;

   typedef enum logic {
      ISA_WORD    = 1'b0,
      ISA_COMPACT = 1'b1
   } isa_mode_e;

   // Kind of update chosen for the address register in one cycle
   typedef enum logic [1:0] {
      UPD_HOLD = 2'd0,
      UPD_STEP = 2'd1,
      UPD_LOAD = 2'd2
   } pc_upd_e;

   function automatic isa_mode_e to_mode(input logic raw);
      return raw ? ISA_COMPACT : ISA_WORD;
   endfunction

endpackage

// File: rtl/pc_step_gen.sv
module pc_step_gen
   import pc_ofs_pkg::*;
#(
   parameter int unsigned AW          = 32,
   parameter int unsigned WORD_STEP   = 4,
   parameter int unsigned NARROW_STEP = 2,
   parameter int unsigned WIDE_STEP   = 4
) (
   input  isa_mode_e        mode_i,
   input  logic             wide_i,
   output logic [AW-1:0]    step_o
);

   localparam logic [AW-1:0] WORD_INC   = AW'(WORD_STEP);
   localparam logic [AW-1:0] NARROW_INC = AW'(NARROW_STEP);
   localparam logic [AW-1:0] WIDE_INC   = AW'(WIDE_STEP);

   if (WORD_STEP == 0 || NARROW_STEP == 0 || WIDE_STEP == 0) begin : g_bad_step
      $error("pc_step_gen: step sizes must be non-zero");
   end
   if (NARROW_STEP > WIDE_STEP) begin : g_bad_order
      $error("pc_step_gen: narrow step must not exceed wide step");
   end

   always_comb begin
      unique case (mode_i)
         ISA_WORD:    step_o = WORD_INC;
         ISA_COMPACT: step_o = wide_i ? WIDE_INC : NARROW_INC;
         default:     step_o = WORD_INC;
      endcase
   end

endmodule

// File: rtl/pc_target_align.sv
module pc_target_align
   import pc_ofs_pkg::*;
#(
   parameter int unsigned AW           = 32,
   parameter int unsigned WORD_BYTES   = 4,
   parameter int unsigned COMPACT_BYTES = 2,
   parameter bit          ALIGN_EN     = 1'b1
) (
   input  isa_mode_e        mode_i,
   input  logic [AW-1:0]    raw_i,
   output logic [AW-1:0]    tgt_o
);

   localparam logic [AW-1:0] WORD_MASK    = ~AW'(WORD_BYTES - 1);
   localparam logic [AW-1:0] COMPACT_MASK = ~AW'(COMPACT_BYTES - 1);

   if ((WORD_BYTES & (WORD_BYTES - 1)) != 0 || WORD_BYTES == 0) begin : g_bad_word
      $error("pc_target_align: WORD_BYTES must be a power of two");
   end
   if ((COMPACT_BYTES & (COMPACT_BYTES - 1)) != 0 || COMPACT_BYTES == 0) begin : g_bad_cmp
      $error("pc_target_align: COMPACT_BYTES must be a power of two");
   end

   if (ALIGN_EN) begin : g_masked
      logic [AW-1:0] mask;
      always_comb begin
         mask  = (mode_i == ISA_COMPACT) ? COMPACT_MASK : WORD_MASK;
         tgt_o = raw_i & mask;
      end
   end else begin : g_passthru
      logic unused_mode;
      assign unused_mode = mode_i;
      assign tgt_o       = raw_i;
   end

endmodule

// File: rtl/pc_read_view.sv
module pc_read_view
   import pc_ofs_pkg::*;
#(
   parameter int unsigned AW             = 32,
   parameter int unsigned WORD_OFFSET    = 8,
   parameter int unsigned COMPACT_OFFSET = 4
) (
   input  isa_mode_e        mode_i,
   input  logic [AW-1:0]    addr_i,
   output logic [AW-1:0]    rd_o
);

   localparam logic [AW-1:0] WORD_ADD    = AW'(WORD_OFFSET);
   localparam logic [AW-1:0] COMPACT_ADD = AW'(COMPACT_OFFSET);

   if (WORD_OFFSET >= (1 << 16) || COMPACT_OFFSET >= (1 << 16)) begin : g_bad_ofs
      $error("pc_read_view: offsets are unreasonably large");
   end

   logic [AW-1:0] ofs;

   always_comb begin
      ofs  = (mode_i == ISA_COMPACT) ? COMPACT_ADD : WORD_ADD;
      rd_o = addr_i + ofs;   // wraps modulo 2^AW
   end

endmodule

// File: rtl/pc_ofs_unit.sv
module pc_ofs_unit
   import pc_ofs_pkg::*;
#(
   parameter int unsigned   AW             = 32,
   parameter logic [AW-1:0] RESET_VEC      = 32'h0000_0040,
   parameter int unsigned   WORD_STEP      = 4,
   parameter int unsigned   NARROW_STEP    = 2,
   parameter int unsigned   WIDE_STEP      = 4,
   parameter int unsigned   WORD_OFFSET    = 8,
   parameter int unsigned   COMPACT_OFFSET = 4,
   parameter bit            ALIGN_EN       = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          mode_i,
   input  logic          size_wide_i,
   input  logic          adv_i,
   input  logic          wr_en_i,
   input  logic [31:0]   wr_data_i,
   output logic [31:0]   cur_addr_o,
   output logic [31:0]   pc_rd_o
);

   localparam int unsigned   WORD_ALIGN_BITS = $clog2(WORD_STEP);
   localparam logic [AW-1:0] WORD_LOW_MASK   = AW'(WORD_STEP - 1);
   localparam logic [AW-1:0] C_WORD_STEP     = AW'(WORD_STEP);
   localparam logic [AW-1:0] C_NARROW_STEP   = AW'(NARROW_STEP);
   localparam logic [AW-1:0] C_WIDE_STEP     = AW'(WIDE_STEP);
   localparam logic [AW-1:0] C_WORD_OFS      = AW'(WORD_OFFSET);
   localparam logic [AW-1:0] C_CMP_OFS       = AW'(COMPACT_OFFSET);

   if (AW != 32) begin : g_bad_aw
      $error("pc_ofs_unit: port widths are fixed at 32 bits");
   end
   if (WORD_ALIGN_BITS < 1) begin : g_bad_align
      $error("pc_ofs_unit: word step must be at least 2 bytes");
   end
   if ((RESET_VEC & WORD_LOW_MASK) != '0) begin : g_bad_vec
      $error("pc_ofs_unit: reset vector must be word aligned");
   end

   isa_mode_e     mode;
   pc_upd_e       upd;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] addr_d;
   logic [AW-1:0] step;
   logic [AW-1:0] target;
   logic [AW-1:0] rd_val;

   assign mode = to_mode(mode_i);

   pc_step_gen #(
      .AW          (AW),
      .WORD_STEP   (WORD_STEP),
      .NARROW_STEP (NARROW_STEP),
      .WIDE_STEP   (WIDE_STEP)
   ) step_i (
      .mode_i (mode),
      .wide_i (size_wide_i),
      .step_o (step)
   );

   pc_target_align #(
      .AW            (AW),
      .WORD_BYTES    (WORD_STEP),
      .COMPACT_BYTES (NARROW_STEP),
      .ALIGN_EN      (ALIGN_EN)
   ) align_i (
      .mode_i (mode),
      .raw_i  (wr_data_i),
      .tgt_o  (target)
   );

   pc_read_view #(
      .AW             (AW),
      .WORD_OFFSET    (WORD_OFFSET),
      .COMPACT_OFFSET (COMPACT_OFFSET)
   ) view_i (
      .mode_i (mode),
      .addr_i (addr_q),
      .rd_o   (rd_val)
   );

   // Priority: a write beats an advance
   always_comb begin
      if (wr_en_i)    upd = UPD_LOAD;
      else if (adv_i) upd = UPD_STEP;
      else            upd = UPD_HOLD;
   end

   always_comb begin
      unique case (upd)
         UPD_LOAD: addr_d = target;
         UPD_STEP: addr_d = addr_q + step;
         default:  addr_d = addr_q;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) addr_q <= RESET_VEC;
      else         addr_q <= addr_d;
   end

   assign cur_addr_o = addr_q;
   assign pc_rd_o    = rd_val;

   // R2
   word_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && !wr_en_i && !mode_i) |=> (cur_addr_o == $past(cur_addr_o) + C_WORD_STEP));

   // R3
   compact_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && !wr_en_i && mode_i) |=>
         (cur_addr_o == $past(cur_addr_o) + ($past(size_wide_i) ? C_WIDE_STEP : C_NARROW_STEP)));

   // R4
   word_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mode_i |-> (pc_rd_o - cur_addr_o == C_WORD_OFS));

   // R5
   compact_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i |-> (pc_rd_o - cur_addr_o == C_CMP_OFS));

   // R6
   word_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !mode_i) |=> (cur_addr_o[1:0] == 2'b00));

   // R6
   compact_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && mode_i) |=> (cur_addr_o[0] == 1'b0));

   // R7
   write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && adv_i) |=> (cur_addr_o[31:2] == $past(wr_data_i[31:2])));

   // R8
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i && !adv_i) |=> $stable(cur_addr_o));

endmodule

// File: tb/pc_ofs_unit_tb.sv
module pc_ofs_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] RVEC = 32'h0000_0040;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode = 1'b0;
   logic        wide = 1'b0;
   logic        adv = 1'b0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] cur_addr;
   logic [31:0] pc_rd;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   pc_ofs_unit dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .mode_i      (mode),
      .size_wide_i (wide),
      .adv_i       (adv),
      .wr_en_i     (wr),
      .wr_data_i   (wdata),
      .cur_addr_o  (cur_addr),
      .pc_rd_o     (pc_rd)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_expect(input logic m, input logic [31:0] a);
      return a + (m ? 32'd4 : 32'd8);
   endfunction

   task automatic step(input logic m, input logic w, input logic a, input logic e,
                       input logic [31:0] d);
      string req;
      logic [31:0] prev;
      @(negedge clk);
      mode = m; wide = w; adv = a; wr = e; wdata = d;
      prev = exp_addr;
      if (e) begin
         exp_addr = d & (m ? 32'hFFFF_FFFE : 32'hFFFF_FFFC);
         req = a ? "R7" : "R6";
      end else if (a) begin
         exp_addr = exp_addr + (m ? (w ? 32'd4 : 32'd2) : 32'd4);
         req = m ? "R3" : "R2";
         if (exp_addr < prev) req = "R9";
      end else begin
         req = "R8";
      end
      @(posedge clk);
      #1;
      check(req, cur_addr, exp_addr);
      check(m ? "R5" : "R4", pc_rd, rd_expect(m, exp_addr));
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [31:0] bases [6];
      bases[0] = 32'h0000_0000;
      bases[1] = 32'h0000_1000;
      bases[2] = 32'h8000_0002;
      bases[3] = 32'hFFFF_FFF8;
      bases[4] = 32'hFFFF_FFFC;
      bases[5] = 32'hFFFF_FFFE;

      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1", cur_addr, RVEC);
      @(negedge clk);
      rst_n = 1'b1;
      exp_addr = RVEC;
      @(posedge clk);
      #1;
      check("R1", cur_addr, RVEC);
      check("R10", pc_rd, RVEC + 32'd8);

      // Near-exhaustive sweep over bases, low bits, modes and controls
      for (int b = 0; b < 6; b++) begin
         for (int lo = 0; lo < 4; lo++) begin
            for (int ctl = 0; ctl < 16; ctl++) begin
               // establish base in compact mode so bit 1 survives
               step(1'b1, 1'b0, 1'b0, 1'b1, bases[b]);
               step(ctl[0], ctl[1], ctl[2], ctl[3], bases[b] ^ 32'(lo) ^ 32'h10);
               // follow-up advance to cover chained steps
               step(ctl[0], ~ctl[1], 1'b1, 1'b0, 32'h0);
            end
         end
      end

      // R5/R10: compact read same for both sizes, in the same cycle
      step(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_2002);
      @(negedge clk);
      wr = 1'b0; adv = 1'b0; wide = 1'b1;
      #1;
      check("R5", pc_rd, 32'h0000_2006);
      wide = 1'b0;
      #1;
      check("R5", pc_rd, 32'h0000_2006);
      mode = 1'b0;
      #1;
      check("R10", pc_rd, 32'h0000_200A);

      // R9: directed wrap in both paths
      step(1'b1, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFE);
      check("R9", pc_rd, 32'h0000_0002);
      step(1'b1, 1'b0, 1'b1, 1'b0, 32'h0);
      check("R9", cur_addr, 32'h0000_0000);

      // R1: reset mid-run
      step(1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
      @(negedge clk);
      adv = 1'b1; wr = 1'b1; wdata = 32'h1234_5678;
      rst_n = 1'b0;
      #1;
      check("R1", cur_addr, RVEC);
      @(posedge clk);
      #1;
      check("R1", cur_addr, RVEC);
      @(negedge clk);
      adv = 1'b0; wr = 1'b0; mode = 1'b0;
      rst_n = 1'b1;
      exp_addr = RVEC;
      step(1'b0, 1'b0, 1'b0, 1'b0, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule